// File: doc/BRIEF.md
# Carry-Chain Integer ALU with Status Flags

This block is a purely combinational integer arithmetic/logic unit for a processor datapath. It takes two operands of equal width and a 4-bit operation code, and produces a result word plus two status bits: a zero indicator and a signed-overflow indicator. There are no clock or reset inputs. The output follows the inputs after the logic settles.

The arithmetic path is a single ripple carry chain. Each bit position has a full adder: the sum bit is the XOR of the two inputs and the incoming carry, and the outgoing carry is their majority. Subtraction uses the same chain. It inverts every bit of the second operand and forces the chain's carry-in to 1. The signed overflow bit is the XOR of the carry entering the top bit and the carry leaving it. The two set-less-than operations derive their answer from the same subtraction: signed uses the sign of the difference XOR the overflow, and unsigned uses the inverted carry out.

Operands arrive already extended to full width. Exceptions on overflow are left to the consumer of the flag. The style's state-machine layout does not apply, because the block holds no state.

Top module: `carry_alu`

## Requirements
- R1: With op_sel 4'b0010 (signed add) or 4'b0011 (unsigned add), result equals opnd_a + opnd_b modulo 2^WIDTH.
- R2: With op_sel 4'b0110 (signed subtract) or 4'b0111 (unsigned subtract), result equals opnd_a - opnd_b modulo 2^WIDTH.
- R3: ovf_flag is 0 for every op_sel other than 4'b0010 and 4'b0110; the unsigned add and subtract never raise it.
- R4: For 4'b0010, ovf_flag is 1 exactly when both operands have the same top bit and the result's top bit differs from it.
- R5: For 4'b0110, ovf_flag is 1 exactly when the operands' top bits differ and the result's top bit differs from opnd_a's top bit.
- R6: Bitwise codes give AND for 4'b0000, OR for 4'b0001, XOR for 4'b0100 and NOR for 4'b1100.
- R7: With op_sel 4'b1000, bit 0 of result is 1 exactly when opnd_a < opnd_b as two's-complement values, and all other result bits are 0.
- R8: With op_sel 4'b1001, bit 0 of result is 1 exactly when opnd_a < opnd_b as unsigned values, and all other result bits are 0.
- R9: zero_flag is 1 exactly when every result bit is 0, under every op_sel.
- R10: Any op_sel not listed above yields a result of 0, so zero_flag is 1 and ovf_flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend for subtract) |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtract) |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the block. One uses the default WIDTH of 32. The other uses WIDTH of 4, small enough that every operand pair under every one of the sixteen op codes is applied, which covers each sign-boundary and carry-out combination exhaustively. The 32-bit copy runs seeded random operands across all codes. It also runs directed cases at the most-positive and most-negative values, where overflow and the signed-versus-unsigned comparisons disagree.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_ADDU = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_SUB  = 4'b0110,
        OP_SUBU = 4'b0111,
        OP_SLT  = 4'b1000,
        OP_SLTU = 4'b1001,
        OP_NOR  = 4'b1100
    } alu_op_e;

    function automatic logic op_uses_sub(input logic [3:0] code);
        return (code == OP_SUB) || (code == OP_SUBU) ||
               (code == OP_SLT) || (code == OP_SLTU);
    endfunction

    function automatic logic op_is_signed_arith(input logic [3:0] code);
        return (code == OP_ADD) || (code == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_ripple_addsub.sv
module alu_ripple_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top_out,
    output logic             carry_top_in
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign chain[0] = sub_mode;
    assign b_eff    = in_b ^ {WIDTH{sub_mode}};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = in_a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (in_a[i] & b_eff[i]) |
                            (in_a[i] & chain[i]) |
                            (b_eff[i] & chain[i]);
    end

    assign carry_top_out = chain[WIDTH];
    assign carry_top_in  = chain[WIDTH-1];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] and_v,
    output logic [WIDTH-1:0] or_v,
    output logic [WIDTH-1:0] xor_v,
    output logic [WIDTH-1:0] nor_v
);
    assign and_v = in_a & in_b;
    assign or_v  = in_a | in_b;
    assign xor_v = in_a ^ in_b;
    assign nor_v = ~(in_a | in_b);
endmodule

// File: rtl/alu_compare.sv
module alu_compare (
    input  logic diff_sign,
    input  logic raw_ovf,
    input  logic carry_out,
    output logic lt_signed,
    output logic lt_unsigned
);
    // Signed: the true sign of a-b is the computed sign corrected by overflow.
    assign lt_signed   = diff_sign ^ raw_ovf;
    // Unsigned: no carry out of a + ~b + 1 means a borrow occurred.
    assign lt_unsigned = ~carry_out;
endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import carry_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);
    localparam int MSB = WIDTH - 1;

    logic             sub_mode;
    logic [WIDTH-1:0] arith_sum;
    logic             c_out;
    logic             c_in_top;
    logic             raw_ovf;
    logic [WIDTH-1:0] and_v, or_v, xor_v, nor_v;
    logic             lt_s, lt_u;

    assign sub_mode = op_uses_sub(op_sel);

    alu_ripple_addsub #(.WIDTH(WIDTH)) u_addsub (
        .in_a          (opnd_a),
        .in_b          (opnd_b),
        .sub_mode      (sub_mode),
        .sum           (arith_sum),
        .carry_top_out (c_out),
        .carry_top_in  (c_in_top)
    );

    assign raw_ovf = c_out ^ c_in_top;

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .in_a  (opnd_a),
        .in_b  (opnd_b),
        .and_v (and_v),
        .or_v  (or_v),
        .xor_v (xor_v),
        .nor_v (nor_v)
    );

    alu_compare u_cmp (
        .diff_sign   (arith_sum[MSB]),
        .raw_ovf     (raw_ovf),
        .carry_out   (c_out),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    always_comb begin
        result = '0;
        case (op_sel)
            OP_AND:                  result = and_v;
            OP_OR:                   result = or_v;
            OP_XOR:                  result = xor_v;
            OP_NOR:                  result = nor_v;
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU:         result = arith_sum;
            OP_SLT:                  result = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU:                 result = {{(WIDTH-1){1'b0}}, lt_u};
            default:                 result = '0;
        endcase
    end

    assign zero_flag = (result == '0);
    assign ovf_flag  = op_is_signed_arith(op_sel) & raw_ovf;
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             ovf_flag
);
    logic [WIDTH-1:0] ref_add, ref_sub;
    assign ref_add = opnd_a + opnd_b;
    assign ref_sub = opnd_a - opnd_b;

    always_comb begin
        // R1
        p_add_value_r1: assert (!(op_sel == 4'b0010 || op_sel == 4'b0011) || result == ref_add)
            else $error("R1 add mismatch");
        // R2
        p_sub_value_r2: assert (!(op_sel == 4'b0110 || op_sel == 4'b0111) || result == ref_sub)
            else $error("R2 subtract mismatch");
        // R3
        p_no_overflow_r3: assert (op_sel == 4'b0010 || op_sel == 4'b0110 || !ovf_flag)
            else $error("R3 overflow on non-signed op");
        // R4
        p_add_ovf_r4: assert (op_sel != 4'b0010 ||
                ovf_flag == ((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) &&
                             (ref_add[WIDTH-1] != opnd_a[WIDTH-1])))
            else $error("R4 add overflow rule");
        // R5
        p_sub_ovf_r5: assert (op_sel != 4'b0110 ||
                ovf_flag == ((opnd_a[WIDTH-1] != opnd_b[WIDTH-1]) &&
                             (ref_sub[WIDTH-1] != opnd_a[WIDTH-1])))
            else $error("R5 subtract overflow rule");
        // R7, R8
        p_slt_upper_r7: assert (!(op_sel == 4'b1000 || op_sel == 4'b1001) || result[WIDTH-1:1] == '0)
            else $error("R7 compare upper bits nonzero");
        p_sltu_bit_r8: assert (op_sel != 4'b1001 || result[0] == (opnd_a < opnd_b))
            else $error("R8 unsigned compare");
        // R9
        p_zero_flag_r9: assert (zero_flag == (result == '0))
            else $error("R9 zero flag");
    end
endmodule

bind carry_alu carry_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/carry_alu_tb_top.sv
module carry_alu_tb_top;
    localparam int WIDE   = 32;
    localparam int NARROW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk; // 4-unit period: 250 MHz with 1 ns units

    logic [WIDE-1:0]   a32, b32, r32;
    logic [3:0]        op32;
    logic              z32, v32;
    logic [NARROW-1:0] a4, b4, r4;
    logic [3:0]        op4;
    logic              z4, v4;

    carry_alu #(.WIDTH(WIDE)) dut_i (
        .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
        .result(r32), .zero_flag(z32), .ovf_flag(v32));

    carry_alu #(.WIDTH(NARROW)) dut_n (
        .opnd_a(a4), .opnd_b(b4), .op_sel(op4),
        .result(r4), .zero_flag(z4), .ovf_flag(v4));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Returns {ovf, zero, result[63:0]}
    function automatic logic [65:0] model(input logic [3:0] op,
                                          input longint unsigned a,
                                          input longint unsigned b,
                                          input int w);
        longint unsigned m, r, sb;
        longint sa_v, sb_v;
        logic ovf, as, bs, rs;
        m   = (64'd1 << w) - 1;
        sb  = 64'd1 << (w - 1);
        a   = a & m;
        b   = b & m;
        as  = (a & sb) != 0;
        bs  = (b & sb) != 0;
        r   = 0;
        ovf = 0;
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0100: r = a ^ b;
            4'b1100: r = ~(a | b) & m;
            4'b0010, 4'b0011: begin
                r  = (a + b) & m;
                rs = (r & sb) != 0;
                if (op == 4'b0010) ovf = (as == bs) && (rs != as);
            end
            4'b0110, 4'b0111: begin
                r  = (a - b) & m;
                rs = (r & sb) != 0;
                if (op == 4'b0110) ovf = (as != bs) && (rs != as);
            end
            4'b1000: begin
                sa_v = as ? longint'(a) - longint'(m) - 1 : longint'(a);
                sb_v = bs ? longint'(b) - longint'(m) - 1 : longint'(b);
                r = (sa_v < sb_v) ? 1 : 0;
            end
            4'b1001: r = (a < b) ? 1 : 0;
            default: r = 0;
        endcase
        return {ovf, (r == 0), r};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'b0000, 4'b0001, 4'b0100, 4'b1100: return "R6";
            4'b0010: return "R1/R4";
            4'b0011: return "R1/R3";
            4'b0110: return "R2/R5";
            4'b0111: return "R2/R3";
            4'b1000: return "R7";
            4'b1001: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic run32(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [65:0] e;
        @(posedge clk);
        a32 = a; b32 = b; op32 = op;
        @(negedge clk);
        e = model(op, 64'(a), 64'(b), WIDE);
        n_checks++;
        if (r32 !== e[31:0] || z32 !== e[64] || v32 !== e[65]) begin
            n_fail++;
            $display("FAIL %s (R9 zero) w32 op=%b a=%h b=%h: got r=%h z=%b v=%b exp r=%h z=%b v=%b",
                     tag_of(op), op, a, b, r32, z32, v32, e[31:0], e[64], e[65]);
        end
    endtask

    task automatic run4(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
        logic [65:0] e;
        @(posedge clk);
        a4 = a; b4 = b; op4 = op;
        @(negedge clk);
        e = model(op, 64'(a), 64'(b), NARROW);
        n_checks++;
        if (r4 !== e[3:0] || z4 !== e[64] || v4 !== e[65]) begin
            n_fail++;
            $display("FAIL %s (R9 zero) w4 op=%b a=%h b=%h: got r=%h z=%b v=%b exp r=%h z=%b v=%b",
                     tag_of(op), op, a, b, r4, z4, v4, e[3:0], e[64], e[65]);
        end
    endtask

    initial begin
        logic [3:0] ops [10] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                                 4'b0110, 4'b0111, 4'b1000, 4'b1001, 4'b1100};
        int unsigned seed;
        a32 = '0; b32 = '0; op32 = '0;
        a4 = '0; b4 = '0; op4 = '0;
        seed = 32'd20250611;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state after reset: AND of zeros, R9 zero flag set, R3 no overflow
        @(negedge clk);
        n_checks++;
        if (r32 !== '0 || z32 !== 1'b1 || v32 !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 idle: got r=%h z=%b v=%b exp r=0 z=1 v=0", r32, z32, v32);
        end

        // Directed corners at the sign boundary (R4, R5, R7, R8, R3)
        run32(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001); // R4 overflow
        run32(4'b0010, 32'h8000_0000, 32'h8000_0000); // R4 overflow, R9 zero
        run32(4'b0010, 32'h7FFF_FFFF, 32'h8000_0000); // R4 mixed signs none
        run32(4'b0011, 32'h7FFF_FFFF, 32'h0000_0001); // R3 unsigned silent
        run32(4'b0110, 32'h8000_0000, 32'h0000_0001); // R5 overflow
        run32(4'b0110, 32'h0000_0000, 32'h8000_0000); // R5 overflow
        run32(4'b0111, 32'h8000_0000, 32'h0000_0001); // R3 unsigned silent
        run32(4'b0110, 32'h1234_5678, 32'h1234_5678); // R2, R9 zero
        run32(4'b1000, 32'h8000_0000, 32'h0000_0001); // R7 true
        run32(4'b1001, 32'h8000_0000, 32'h0000_0001); // R8 false
        run32(4'b1000, 32'h7FFF_FFFF, 32'h8000_0000); // R7 false (overflow in diff)
        run32(4'b1001, 32'h0000_0001, 32'hFFFF_FFFF); // R8 true
        run32(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF); // R6 NOR zero
        run32(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R10 unused
        run32(4'b1111, 32'h7FFF_FFFF, 32'h0000_0001); // R10 unused

        // Exhaustive narrow instance: every code, every operand pair
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(4'(op), 4'(a), 4'(b));

        // Random wide stimulus over all valid codes plus unused ones
        for (int k = 0; k < 2500; k++) begin
            logic [3:0] op;
            if ((k % 8) == 7) op = 4'($urandom());
            else              op = ops[$urandom() % 10];
            run32(op, $urandom(), $urandom());
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule